// File: doc/BRIEF.md
# Short Relative Branch Resolver

This block takes a short relative branch that has already been decoded and resolves it. It works out whether the branch is taken and returns the program counter that fetch should use next. The block covers two branch forms.

The condition form uses a 4-bit condition selector. It tests the processor's status flags. When the alternate-condition prefix flag is present, some selectors test other things instead: the half-carry flag, the interrupt mask, or the level of the external interrupt line.

The bit-test form uses a memory byte that was read before the branch. It selects one bit of that byte and jumps on either its set or its clear state.

In both forms a signed 8-bit displacement is added to the address of the following instruction. The sum wraps in a 24-bit address space. Selectors that have no meaning under the prefix raise an illegal indication and never branch. All results are registered and appear one clock after the request, together with a valid strobe.

Top module: `rel_branch_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid`, `taken` and `illegal` become 0 and `target` becomes 0.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge. `taken`, `illegal` and `target` reflect the inputs sampled at that same edge.
- R3: `flags_in` carries C at bit 0, Z at bit 1, N at bit 2, I0 at bit 3, H at bit 4, I1 at bit 5 and V at bit 6. In condition form (`bit_mode`=0) without the prefix, selectors 0..7 branch as follows:
  - 0: always
  - 1: never
  - 2: when C=0 and Z=0
  - 3: when C=1 or Z=1
  - 4: when C=0
  - 5: when C=1
  - 6: when Z=0
  - 7: when Z=1
- R4: In condition form without the prefix, selectors 8..F branch as follows:
  - 8: when V=0
  - 9: when V=1
  - A: when N=0
  - B: when N=1
  - C: when Z=0 and N=V
  - D: when Z=1 or N≠V
  - E: when N=V
  - F: when N≠V

  Selectors A and B behave the same way with the prefix.
- R5: With the prefix (`alt_sel`=1), selector 8 branches when H=0 and selector 9 branches when H=1.
- R6: With the prefix, selector C branches when the interrupt mask is clear and selector D branches when it is set. The mask counts as set only when I1 and I0 are both 1.
- R7: With the prefix, selector E branches when `irq_line` is 0 and selector F branches when `irq_line` is 1.
- R8: With the prefix, selectors 0..7 give `illegal`=1 and `taken`=0. No other condition-form input raises `illegal`.
- R9: In bit-test form (`bit_mode`=1), the bit of `mem_byte` chosen by `bit_idx` is tested. With `clear_sense`=0 the branch is taken when that bit is 1; with `clear_sense`=1 it is taken when that bit is 0. `cond_sel`, `alt_sel`, `flags_in` and `irq_line` have no effect in this form, and `illegal` is 0.
- R10: When the branch is taken, `target` = `next_pc` + sign-extended `rel_off`, modulo 2^24.
- R11: When the branch is not taken, `target` = `next_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| bit_mode | input | 1 | 1 selects the bit-test form, 0 selects the condition form |
| cond_sel | input | 4 | Condition selector |
| alt_sel | input | 1 | Alternate-condition prefix present |
| flags_in | input | 7 | Status flags {V,I1,H,I0,N,Z,C} |
| irq_line | input | 1 | External interrupt line level |
| mem_byte | input | 8 | Operand byte for the bit-test form |
| bit_idx | input | 3 | Bit position to test |
| clear_sense | input | 1 | 1 = jump on a clear bit, 0 = jump on a set bit |
| next_pc | input | 24 | Address of the instruction after the branch |
| rel_off | input | 8 | Signed displacement |
| out_valid | output | 1 | Registered request strobe |
| taken | output | 1 | Branch taken |
| target | output | 24 | Next fetch address |
| illegal | output | 1 | Selector undefined under the prefix |

## Verification
The condition form is driven exhaustively over every selector, both prefix states, all 128 flag combinations and both interrupt-line levels. This separates each selector from its paired complement, shows that the prefix changes only selectors 8/9 and C..F, and shows that a mask with only one bit set is not treated as masked.

The bit-test form is swept over every byte value, bit position and sense, while the selector and prefix change at random. This shows that only the addressed bit and the sense matter.

Displacements of +127, -128 and 0 placed at the top and bottom of the address space check sign extension and 24-bit wrap. Idle cycles placed between requests check that the valid strobe tracks the request one cycle late.

// File: rtl/rbu_pkg.sv
package rbu_pkg;

    typedef struct packed {
        logic v;
        logic i1;
        logic h;
        logic i0;
        logic n;
        logic z;
        logic c;
    } flags_t;

    typedef struct packed {
        logic hit;
        logic bad;
    } cond_res_t;

    // Selector pairs: the even member holds the base test, the odd member its complement.
    typedef enum logic [2:0] {
        PAIR_ALWAYS = 3'd0,
        PAIR_UGT    = 3'd1,
        PAIR_NC     = 3'd2,
        PAIR_NZ     = 3'd3,
        PAIR_NV     = 3'd4,
        PAIR_PL     = 3'd5,
        PAIR_SGT    = 3'd6,
        PAIR_SGE    = 3'd7
    } pair_e;

    function automatic cond_res_t eval_cond(input logic [3:0] sel, input logic alt,
                                            input flags_t f, input logic irq);
        cond_res_t r;
        logic      base;
        r    = '0;
        base = 1'b0;
        if (alt && !sel[3]) begin
            r.bad = 1'b1;
        end else begin
            case (pair_e'(sel[3:1]))
                PAIR_ALWAYS: base = 1'b1;
                PAIR_UGT:    base = !f.c && !f.z;
                PAIR_NC:     base = !f.c;
                PAIR_NZ:     base = !f.z;
                PAIR_NV:     base = alt ? !f.h : !f.v;
                PAIR_PL:     base = !f.n;
                PAIR_SGT:    base = alt ? !(f.i1 && f.i0) : (!f.z && (f.n == f.v));
                PAIR_SGE:    base = alt ? !irq : (f.n == f.v);
                default:     base = 1'b0;
            endcase
            r.hit = base ^ sel[0];
        end
        return r;
    endfunction

endpackage

// File: rtl/rbu_cond_eval.sv
module rbu_cond_eval
    import rbu_pkg::*;
(
    input  logic [3:0] sel,
    input  logic       alt,
    input  flags_t     flags,
    input  logic       irq,
    output logic       hit,
    output logic       bad
);
    cond_res_t res;

    always_comb begin
        res = eval_cond(sel, alt, flags, irq);
        hit = res.hit;
        bad = res.bad;
    end
endmodule

// File: rtl/rbu_bit_test.sv
module rbu_bit_test #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [IDX_W-1:0]  idx,
    input  logic              on_clear,
    output logic              hit
);
    logic [DATA_W-1:0] lane_match;

    // One decoded lane per bit; the selected lane drives the result.
    for (genvar g = 0; g < DATA_W; g++) begin : g_lane
        assign lane_match[g] = (idx == IDX_W'(g)) && (data[g] ^ on_clear);
    end

    assign hit = |lane_match;
endmodule

// File: rtl/rbu_target_add.sv
module rbu_target_add #(
    parameter int PC_W  = 24,
    parameter int OFF_W = 8
) (
    input  logic [PC_W-1:0]  base_pc,
    input  logic [OFF_W-1:0] disp,
    input  logic             use_disp,
    output logic [PC_W-1:0]  dest
);
    localparam int EXT_W = PC_W - OFF_W;

    logic [PC_W-1:0] disp_ext;
    logic [PC_W-1:0] sum;

    assign disp_ext = {{EXT_W{disp[OFF_W-1]}}, disp};
    assign sum      = base_pc + disp_ext;
    assign dest     = use_disp ? sum : base_pc;
endmodule

// File: rtl/rel_branch_unit.sv
module rel_branch_unit
    import rbu_pkg::*;
#(
    parameter int PC_W   = 24,
    parameter int OFF_W  = 8,
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              bit_mode,
    input  logic [3:0]        cond_sel,
    input  logic              alt_sel,
    input  logic [6:0]        flags_in,
    input  logic              irq_line,
    input  logic [DATA_W-1:0] mem_byte,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              clear_sense,
    input  logic [PC_W-1:0]   next_pc,
    input  logic [OFF_W-1:0]  rel_off,
    output logic              out_valid,
    output logic              taken,
    output logic [PC_W-1:0]   target,
    output logic              illegal
);
    logic            cond_hit;
    logic            cond_bad;
    logic            bit_hit;
    logic            take_d;
    logic            bad_d;
    logic [PC_W-1:0] dest_d;

    rbu_cond_eval u_cond (
        .sel   (cond_sel),
        .alt   (alt_sel),
        .flags (flags_t'(flags_in)),
        .irq   (irq_line),
        .hit   (cond_hit),
        .bad   (cond_bad)
    );

    rbu_bit_test #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bit (
        .data     (mem_byte),
        .idx      (bit_idx),
        .on_clear (clear_sense),
        .hit      (bit_hit)
    );

    assign take_d = bit_mode ? bit_hit : cond_hit;
    assign bad_d  = !bit_mode && cond_bad;

    rbu_target_add #(.PC_W(PC_W), .OFF_W(OFF_W)) u_add (
        .base_pc  (next_pc),
        .disp     (rel_off),
        .use_disp (take_d),
        .dest     (dest_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            taken     <= 1'b0;
            illegal   <= 1'b0;
            target    <= '0;
        end else begin
            out_valid <= in_valid;
            taken     <= take_d;
            illegal   <= bad_d;
            target    <= dest_d;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R8
    prefix_low_bad_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !bit_mode && alt_sel && !cond_sel[3]) |=> (illegal && !taken));

    // R9
    bit_form_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bit_mode) |=> !illegal);

    // R3
    always_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !bit_mode && !alt_sel && cond_sel == 4'h0) |=> taken);

    // R3
    never_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !bit_mode && !alt_sel && cond_sel == 4'h1) |=> !taken);

    // R11
    fallthrough_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !bit_mode && !alt_sel && cond_sel == 4'h1) |=> (target == $past(next_pc)));
endmodule

// File: tb/rel_branch_unit_bench.sv
`timescale 1ns/1ps
module rel_branch_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        bit_mode = 1'b0;
    logic [3:0]  cond_sel = '0;
    logic        alt_sel = 1'b0;
    logic [6:0]  flags_in = '0;
    logic        irq_line = 1'b0;
    logic [7:0]  mem_byte = '0;
    logic [2:0]  bit_idx = '0;
    logic        clear_sense = 1'b0;
    logic [23:0] next_pc = '0;
    logic [7:0]  rel_off = '0;
    logic        out_valid;
    logic        taken;
    logic [23:0] target;
    logic        illegal;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    rel_branch_unit u_rel_branch_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .bit_mode(bit_mode),
        .cond_sel(cond_sel), .alt_sel(alt_sel), .flags_in(flags_in),
        .irq_line(irq_line), .mem_byte(mem_byte), .bit_idx(bit_idx),
        .clear_sense(clear_sense), .next_pc(next_pc), .rel_off(rel_off),
        .out_valid(out_valid), .taken(taken), .target(target), .illegal(illegal)
    );

    // Behavioural model taken from the requirement text.
    function automatic void model(output bit t, output bit il, output logic [23:0] tg);
        bit c  = flags_in[0];
        bit z  = flags_in[1];
        bit n  = flags_in[2];
        bit i0 = flags_in[3];
        bit h  = flags_in[4];
        bit i1 = flags_in[5];
        bit v  = flags_in[6];
        int o;
        int s;
        t  = 0;
        il = 0;
        if (bit_mode) begin
            t = (((mem_byte >> bit_idx) & 8'h01) != 0) ? !clear_sense : clear_sense;
        end else if (alt_sel && cond_sel < 8) begin
            il = 1;
        end else begin
            case (cond_sel)
                4'h0: t = 1;
                4'h1: t = 0;
                4'h2: t = (c == 0) && (z == 0);
                4'h3: t = (c == 1) || (z == 1);
                4'h4: t = (c == 0);
                4'h5: t = (c == 1);
                4'h6: t = (z == 0);
                4'h7: t = (z == 1);
                4'h8: t = alt_sel ? (h == 0) : (v == 0);
                4'h9: t = alt_sel ? (h == 1) : (v == 1);
                4'hA: t = (n == 0);
                4'hB: t = (n == 1);
                4'hC: t = alt_sel ? !(i1 && i0) : ((z == 0) && (n == v));
                4'hD: t = alt_sel ? (i1 && i0) : ((z == 1) || (n != v));
                4'hE: t = alt_sel ? (irq_line == 0) : (n == v);
                default: t = alt_sel ? (irq_line == 1) : (n != v);
            endcase
        end
        o = int'(rel_off);
        if (o > 127) o = o - 256;
        s = int'(next_pc) + (t ? o : 0);
        if (s < 0) s = s + (1 << 24);
        if (s >= (1 << 24)) s = s - (1 << 24);
        tg = s[23:0];
    endfunction

    function automatic string tag_for(int p, int cc);
        if (p != 0 && cc < 8) return "R8";
        if (cc < 8) return "R3";
        if (p == 0 || cc == 10 || cc == 11) return "R4";
        if (cc < 10) return "R5";
        if (cc < 14) return "R6";
        return "R7";
    endfunction

    // Inputs are set by the caller just after a falling edge; outputs are compared at the next one.
    task automatic step(input string tag);
        bit          et;
        bit          ei;
        logic [23:0] eg;
        bit          ev;
        model(et, ei, eg);
        ev = in_valid;
        @(negedge clk);
        checks++;
        if (out_valid !== ev || taken !== et || illegal !== ei || target !== eg) begin
            fails++;
            $display("FAIL %s: got v=%0b t=%0b il=%0b tg=%06h, expected v=%0b t=%0b il=%0b tg=%06h",
                     tag, out_valid, taken, illegal, target, ev, et, ei, eg);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got no finish, expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        in_valid = 1'b1;
        cond_sel = 4'h0;
        next_pc  = 24'h00ABCD;
        rel_off  = 8'h10;
        repeat (3) @(negedge clk);
        // R1: reset holds everything at zero even with a live request
        checks++;
        if (out_valid !== 1'b0 || taken !== 1'b0 || illegal !== 1'b0 || target !== 24'h0) begin
            fails++;
            $display("FAIL R1: got v=%0b t=%0b il=%0b tg=%06h, expected all zero",
                     out_valid, taken, illegal, target);
        end
        rst = 1'b0;

        // R10: taken targets with sign extension and wrap
        in_valid = 1'b1; bit_mode = 1'b0; alt_sel = 1'b0; cond_sel = 4'h0;
        next_pc = 24'hFFFFF0; rel_off = 8'h7F; step("R10");
        next_pc = 24'h000005; rel_off = 8'h80; step("R10");
        next_pc = 24'h123456; rel_off = 8'h00; step("R10");
        next_pc = 24'h800000; rel_off = 8'hFF; step("R10");
        // R11: not-taken target is the fall-through address
        cond_sel = 4'h1; next_pc = 24'h3A5C7E; rel_off = 8'h55; step("R11");
        next_pc = 24'hFFFFFF; rel_off = 8'h01; step("R11");
        // R2: idle cycles drop the strobe
        in_valid = 1'b0; step("R2");
        in_valid = 1'b1; step("R2");

        // R3..R8: every selector, prefix, flag pattern and line level
        for (int p = 0; p < 2; p++) begin
            for (int cc = 0; cc < 16; cc++) begin
                for (int f = 0; f < 128; f++) begin
                    for (int q = 0; q < 2; q++) begin
                        bit_mode = 1'b0;
                        alt_sel  = p[0];
                        cond_sel = cc[3:0];
                        flags_in = f[6:0];
                        irq_line = q[0];
                        mem_byte = 8'($urandom);
                        next_pc  = 24'($urandom);
                        rel_off  = 8'($urandom);
                        in_valid = ($urandom % 16) != 0;
                        step(tag_for(p, cc));
                    end
                end
            end
        end

        // R9: bit-test form, unrelated inputs scrambled
        for (int b = 0; b < 256; b++) begin
            for (int k = 0; k < 8; k++) begin
                for (int s = 0; s < 2; s++) begin
                    bit_mode    = 1'b1;
                    mem_byte    = b[7:0];
                    bit_idx     = k[2:0];
                    clear_sense = s[0];
                    cond_sel    = 4'($urandom);
                    alt_sel     = 1'($urandom);
                    flags_in    = 7'($urandom);
                    irq_line    = 1'($urandom);
                    next_pc     = 24'($urandom);
                    rel_off     = 8'($urandom);
                    in_valid    = 1'b1;
                    step("R9");
                end
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule